// File: doc/BRIEF.md
# Byte-Accessed Reloadable Down-Counter

This block is a 16-bit down-counter. Software reaches it over an 8-bit register bus, with one register for control and one for each byte of the count. Each enabled tick of a prescaled clock-enable input lowers the count by one. When the count is already zero, the next enabled tick instead reloads it from a reload latch and raises a one-cycle underflow request. A control bit halts counting and keeps the value.

The bus is one byte wide, so a 16-bit access takes two transfers. A 16-bit staging buffer keeps each access coherent:

- On a write, the low byte is placed in the buffer first. The high-byte write then commits both bytes together.
- On a read, reading the high byte snapshots the whole count. The later low-byte read returns the half that matches it.

A write-path bit in the control register chooses what a commit loads:

- When the bit is 0, the commit loads both the latch and the counter.
- When the bit is 1, the commit loads the latch only, and the counter takes the new value at its next reload.

Only plain timer mode is built. The two mode-select bits are stored and read back, but every value of them behaves as timer mode.

Top module: `byte_reload_timer`

## Requirements
- R1: After reset the count reads 0xFFFF, the control register reads 0x00 and the underflow request is low.
- R2: Register addresses are: 0 for control, 1 for the count low byte, 2 for the count high byte. A read of the high byte returns count[15:8] and snapshots the full count. A following read of the low byte returns the snapshotted count[7:0], even if the counter has moved since.
- R3: With control bit 0 at 0, a write to address 1 followed by a write to address 2 loads {high, low} into both the counter and the reload latch. The load happens at the clock edge of the high-byte write.
- R4: A write to address 1 alone changes neither the counter nor the reload latch.
- R5: With control bit 0 at 1, the high-byte commit updates only the reload latch. The counter keeps counting from its old value and loads the new latch value at its next reload.
- R6: With control bit 1 at 1, the counter holds its value on ticks. With control bit 1 at 0, counting resumes.
- R7: Each clock edge with the tick input high and counting enabled lowers the count by one. With the tick input low, the count holds.
- R8: An enabled tick while the count is 0x0000 reloads the counter from the latch. The underflow request is high for exactly the one cycle after that edge.
- R9: A high-byte commit that loads the counter in the same cycle as an enabled tick wins: the counter takes the written value, not a decremented one.
- R10: Control bits 3:2 are stored and read back, and every value of them behaves as timer mode. Control bits 7:4 always read 0 and ignore writes.
- R11: A read of address 3 returns 0x00. A write to address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Prescaled count enable |
| addr | input | 2 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while rdEn is high, zero otherwise |
| underflowIrq | output | 1 | One-cycle underflow request |

## Verification
A table of control values and 16-bit words is written and then read back in byte order. This tells the simultaneous-load path apart from the latch-only path, because under the latch-only path the old count must survive.

Directed sequences cover the following:
- Runs of ticks through zero, which separate the plain decrement from the reload and from the timing of the request pulse.
- A high-byte read followed by a tick and then a low-byte read, which shows whether the low half was snapshotted or read live.
- Writes that coincide with ticks, a lone low-byte write, the stop bit, the mode-select bits and the unused address, each of which probes one ordering or isolation rule.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Strobes passed from control to datapath once per cycle
  typedef struct packed {
    logic stageLo;    // low byte goes to the staging buffer
    logic commitHi;   // high byte commits the 16-bit word to the latch
    logic loadCount;  // commit also loads the running counter
    logic snapRead;   // high-byte read snapshots the count
    logic countTick;  // enabled decrement tick
  } timer_strobe_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTRL = 2'd1,
    RD_LO   = 2'd2,
    RD_HI   = 2'd3
  } rd_sel_t;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BUS_W-1:0]  wrData,
  output timer_strobe_t     strobe,
  output rd_sel_t           rdSel,
  output logic [BUS_W-1:0]  ctrlByte,
  output logic              latchOnly,
  output logic              stopBit
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(CTRL_ADDR + 1);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(CTRL_ADDR + 2);
  localparam int USED_W = 2 + SEL_W;

  logic              latchOnlyQ;
  logic              stopQ;
  logic [SEL_W-1:0]  modeSelQ;

  logic hitCtrl, hitLo, hitHi;
  assign hitCtrl = (addr == A_CTRL);
  assign hitLo   = (addr == A_LO);
  assign hitHi   = (addr == A_HI);

  // Control register: only the low USED_W bits are stored
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchOnlyQ <= 1'b0;
      stopQ      <= 1'b0;
      modeSelQ   <= '0;
    end else if (wrEn && hitCtrl) begin
      latchOnlyQ <= wrData[0];
      stopQ      <= wrData[1];
      modeSelQ   <= wrData[2 +: SEL_W];
    end
  end

  // Strobe decode; every mode-select value acts as timer mode
  always_comb begin
    strobe.stageLo   = wrEn && hitLo;
    strobe.commitHi  = wrEn && hitHi;
    strobe.loadCount = wrEn && hitHi && !latchOnlyQ;
    strobe.snapRead  = rdEn && !wrEn && hitHi;
    strobe.countTick = tickEn && !stopQ;
  end

  always_comb begin
    rdSel = RD_NONE;
    if (rdEn) begin
      if (hitCtrl)    rdSel = RD_CTRL;
      else if (hitLo) rdSel = RD_LO;
      else if (hitHi) rdSel = RD_HI;
    end
  end

  // The unstored upper bits read as zero
  assign ctrlByte  = {{(BUS_W-USED_W){1'b0}}, modeSelQ, stopQ, latchOnlyQ};
  assign latchOnly = latchOnlyQ;
  assign stopBit   = stopQ;

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  timer_strobe_t        strobe,
  input  rd_sel_t              rdSel,
  input  logic [BUS_W-1:0]     wrData,
  output logic [BUS_W-1:0]     rdByte,
  output logic [2*BUS_W-1:0]   countVal,
  output logic [2*BUS_W-1:0]   latchVal,
  output logic                 underflowIrq
);

  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] latchQ;
  logic [CNT_W-1:0] stageQ;
  logic             irqQ;
  logic [CNT_W-1:0] commitWord;
  logic             atZero;

  assign commitWord = {wrData, stageQ[BUS_W-1:0]};
  assign atZero     = (countQ == '0);

  // Staging buffer: the low half is written by the low-byte write,
  // the whole word by the high-byte read snapshot
  always_ff @(posedge clk) begin
    if (!rstN)                stageQ <= '0;
    else if (strobe.stageLo)  stageQ[BUS_W-1:0] <= wrData;
    else if (strobe.snapRead) stageQ <= countQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                latchQ <= '1;
    else if (strobe.commitHi) latchQ <= commitWord;
  end

  // A counter load wins over the decrement or reload
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '1;
    end else if (strobe.loadCount) begin
      countQ <= commitWord;
    end else if (strobe.countTick) begin
      if (atZero) countQ <= latchQ;
      else        countQ <= countQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= strobe.countTick && !strobe.loadCount && atZero;
  end

  always_comb begin
    unique case (rdSel)
      RD_HI:   rdByte = countQ[CNT_W-1:BUS_W];
      RD_LO:   rdByte = stageQ[BUS_W-1:0];
      default: rdByte = '0;
    endcase
  end

  assign countVal     = countQ;
  assign latchVal     = latchQ;
  assign underflowIrq = irqQ;

endmodule

// File: rtl/byte_reload_timer.sv
module byte_reload_timer
  import timer_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              underflowIrq
);

  localparam int CNT_W = 2 * BUS_W;

  timer_strobe_t    strobe;
  rd_sel_t          rdSel;
  logic [BUS_W-1:0] ctrlByte;
  logic [BUS_W-1:0] dpByte;
  logic             latchOnly;
  logic             stopBit;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] latchVal;

  timer_ctrl #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .strobe(strobe), .rdSel(rdSel), .ctrlByte(ctrlByte),
    .latchOnly(latchOnly), .stopBit(stopBit)
  );

  timer_datapath #(
    .BUS_W(BUS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel),
    .wrData(wrData), .rdByte(dpByte), .countVal(countVal),
    .latchVal(latchVal), .underflowIrq(underflowIrq)
  );

  assign rdData = (rdSel == RD_CTRL) ? ctrlByte : dpByte;

endmodule

// File: rtl/timer_checks.sv
module timer_checks #(
  parameter int BUS_W     = 8,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [BUS_W-1:0]  rdData,
  input logic              underflowIrq,
  input logic [2*BUS_W-1:0] countVal,
  input logic [2*BUS_W-1:0] latchVal,
  input logic              stopBit,
  input logic              latchOnly
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(CTRL_ADDR + 1);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(CTRL_ADDR + 2);

  // R8: a request only follows an enabled tick at zero
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    underflowIrq |-> $past(countVal == '0 && tickEn && !stopBit));

  // R6: a stopped counter holds unless a commit loads it
  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stopBit && !(wrEn && addr == A_HI)) |=> $stable(countVal));

  // R3: a simultaneous commit leaves counter and latch equal
  p_sim_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_HI && !latchOnly) |=> (countVal == latchVal));

  // R5: a latch-only commit without a tick leaves the count alone
  p_latch_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_HI && latchOnly && !(tickEn && !stopBit))
      |=> $stable(countVal));

  // R4: a low-byte write never touches the latch
  p_lo_isolated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_LO) |=> $stable(latchVal));

  // R10: upper control bits read as zero
  p_ctrl_upper_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == A_CTRL) |-> (rdData[BUS_W-1:4] == '0));

endmodule

bind byte_reload_timer timer_checks #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_checks (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
  .rdEn(rdEn), .rdData(rdData), .underflowIrq(underflowIrq),
  .countVal(countVal), .latchVal(latchVal), .stopBit(stopBit),
  .latchOnly(latchOnly)
);

// File: tb/test_byte_reload_timer.sv
module test_byte_reload_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       underflowIrq;

  int checkCount = 0;
  int failCount  = 0;

  always #2.5 clk = ~clk;

  byte_reload_timer i_byte_reload_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData),
    .underflowIrq(underflowIrq)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] word;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h00, 16'h1234},
    '{8'h01, 16'hABCD},
    '{8'h0C, 16'h00FF},
    '{8'h03, 16'h5A5A},
    '{8'h08, 16'hFF00},
    '{8'h00, 16'h0001}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic wr16(input logic [15:0] v);
    busWr(2'd1, v[7:0]);
    busWr(2'd2, v[15:8]);
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    busRd(2'd2, h);
    busRd(2'd1, l);
    v = {h, l};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    logic [15:0] v, prev;
    logic [7:0]  b, h, l;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irq", underflowIrq, 0);
    rd16(v);     check("R1 count", v, 16'hFFFF);
    busRd(2'd0, b); check("R1 ctrl", b, 8'h00);

    // Vector table: R3 simultaneous / R5 latch-only / R10 readback
    prev = 16'hFFFF;
    foreach (VECS[i]) begin
      busWr(2'd0, VECS[i].ctrl);
      wr16(VECS[i].word);
      rd16(v);
      if (!VECS[i].ctrl[0]) prev = VECS[i].word;
      check(VECS[i].ctrl[0] ? "R5 table" : "R3 table", v, prev);
      busRd(2'd0, b);
      check("R10 table ctrl", b, {4'h0, VECS[i].ctrl[3:0]});
    end
    busWr(2'd0, 8'h00);

    // R7 decrement and hold
    wr16(16'h0005);
    ticks(3);
    rd16(v); check("R7 three ticks", v, 16'h0002);
    repeat (4) @(negedge clk);
    rd16(v); check("R7 tick low holds", v, 16'h0002);

    // R6 stop / resume
    busWr(2'd0, 8'h02);
    ticks(4);
    rd16(v); check("R6 stopped", v, 16'h0002);
    busWr(2'd0, 8'h00);
    ticks(1);
    rd16(v); check("R6 resumed", v, 16'h0001);

    // R8 underflow reload and one-cycle request
    wr16(16'h0002);
    ticks(2);
    check("R8 no irq before zero tick", underflowIrq, 0);
    ticks(1);
    check("R8 irq high", underflowIrq, 1);
    @(negedge clk);
    check("R8 irq one cycle", underflowIrq, 0);
    rd16(v); check("R8 reload", v, 16'h0002);

    // R5 latch-only commit taken at next reload
    wr16(16'h0003);
    busWr(2'd0, 8'h01);
    wr16(16'h0010);
    rd16(v); check("R5 count kept", v, 16'h0003);
    ticks(3);
    rd16(v); check("R5 at zero", v, 16'h0000);
    ticks(1);
    check("R5 irq", underflowIrq, 1);
    rd16(v); check("R5 new reload", v, 16'h0010);
    busWr(2'd0, 8'h00);

    // R9 commit wins over simultaneous tick
    @(negedge clk);
    tickEn = 1'b1;
    busWr(2'd1, 8'h00);
    busWr(2'd2, 8'h01);
    tickEn = 1'b0;
    rd16(v); check("R9 write priority", v, 16'h0100);

    // R2 read snapshot
    wr16(16'h1200);
    busRd(2'd2, h);
    ticks(1);
    busRd(2'd1, l);
    check("R2 high byte", h, 8'h12);
    check("R2 snapshotted low", l, 8'h00);
    rd16(v); check("R2 live after tick", v, 16'h11FF);

    // R4 lone low-byte write
    wr16(16'h0005);
    busWr(2'd1, 8'h77);
    rd16(v); check("R4 count unchanged", v, 16'h0005);
    ticks(6);
    rd16(v); check("R4 latch unchanged", v, 16'h0005);

    // R11 unused address
    busWr(2'd3, 8'hFF);
    busRd(2'd3, b); check("R11 read zero", b, 8'h00);
    busRd(2'd0, b); check("R11 ctrl intact", b, 8'h00);
    rd16(v); check("R11 count intact", v, 16'h0005);

    // R10 upper bits ignored, mode select still counts
    busWr(2'd0, 8'hFC);
    busRd(2'd0, b); check("R10 upper bits", b, 8'h0C);
    ticks(1);
    rd16(v); check("R10 counts in any mode", v, 16'h0004);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule